// File: doc/BRIEF.md
# Top-Byte Address Window Matcher

This block holds a small set of programmable address windows that let accesses bypass page-table translation. Each window is a 32-bit configuration word, written and read as a whole over a simple register port. Half of the windows serve data accesses and the other half serve instruction fetches. A window covers every address whose top byte equals a programmed base byte. A per-bit don't-care mask can widen the covered range in steps of 16 Mbytes. A privilege qualifier can limit the window to user accesses, to supervisor accesses, or to both.

For every presented access the block returns a registered response one cycle later. The response gives a hit flag and the index of the winning window within its pair. It also gives that window's two user attribute bits, which are passed through uninterpreted, its cache-mode field and its write-protect bit. A write that lands in a write-protected window is reported as a fault instead of a hit. The global translation-enable and translation-disable inputs are present on the interface, but window matching ignores them by design.

Top module: `ttw_matcher`

## Requirements
- R1: After reset every configuration word reads back as zero and no access produces a hit or a fault.
- R2: A write on the register port replaces the whole 32-bit word of the selected window (select 0 and 1 are the data windows, 2 and 3 the instruction windows). The word reads back with bits 12, 11, 10, 7, 4, 3, 1 and 0 forced to zero.
- R3: A window covers an access when address bits 31..24 equal configuration bits 31..24 in every position where the mask, configuration bits 23..16, holds a 0. Mask bits that are 1 are don't-care.
- R4: Configuration bit 15 enables the window; with bit 15 at 0 the window never matches.
- R5: Configuration bits 14..13 qualify privilege: 00 matches only user accesses (acc_super = 0), 01 matches only supervisor accesses (acc_super = 1), 10 and 11 match either.
- R6: Instruction fetches (acc_instr = 1) are compared only against windows 2 and 3, and data accesses only against windows 0 and 1.
- R7: When both windows of the selected pair match, the lower one wins: rsp_idx is 0 and its attributes are reported. The response still counts as a hit.
- R8: On a hit or fault, rsp_upa[1] is configuration bit 9 and rsp_upa[0] is bit 8, rsp_cmode is bits 6..5 and rsp_wp is bit 2 of the winning window. With neither hit nor fault, rsp_idx, rsp_upa, rsp_cmode and rsp_wp are all zero.
- R9: A write access (acc_write = 1) whose winning window has bit 2 set drives rsp_fault high for that response only, with rsp_hit low. A read of the same window is a normal hit.
- R10: The xlate_en and xlate_dis inputs have no effect on any response.
- R11: The response to an access appears on the clock edge after acc_valid is sampled, and rsp_valid follows acc_valid with that one-cycle delay. Without acc_valid there is no hit and no fault. A register write and an access in the same cycle see the old configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Window select for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected window |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Logical address of the access |
| acc_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_write | input | 1 | 1 = write, 0 = read |
| xlate_en | input | 1 | Global translation enable (ignored by matching) |
| xlate_dis | input | 1 | Translation disable input (ignored by matching) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window covered the access |
| rsp_fault | output | 1 | Write to a write-protected window |
| rsp_idx | output | 1 | Index of winning window inside its pair |
| rsp_upa | output | 2 | User attribute bits of the winning window |
| rsp_cmode | output | 2 | Cache mode of the winning window |
| rsp_wp | output | 1 | Write-protect bit of the winning window |

## Verification
Directed address patterns test one bit at a time. Exact top bytes and bytes that differ by one bit separate base comparison from mask handling. Bytes that differ only under set mask bits show that masked positions are really ignored. Accesses are repeated as user and supervisor, as instruction and data, and as read and write, so that privilege qualification, pair selection and fault generation are each isolated. Overlapping windows expose the priority order. A long stretch of random configurations and accesses, with the ignored control inputs toggling, is compared every cycle against a behavioural model.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

   localparam int unsigned CFG_W     = 32;
   localparam logic [31:0] RSVD_MASK = 32'h0000_1C9B;

   localparam int unsigned BASE_MSB  = 31;
   localparam int unsigned MASK_MSB  = 23;
   localparam int unsigned EN_BIT    = 15;
   localparam int unsigned PRIV_HI   = 14;
   localparam int unsigned PRIV_LO   = 13;
   localparam int unsigned UPA_HI    = 9;
   localparam int unsigned UPA_LO    = 8;
   localparam int unsigned CM_HI     = 6;
   localparam int unsigned CM_LO     = 5;
   localparam int unsigned WP_BIT    = 2;

   typedef struct packed {
      logic [1:0] upa;
      logic [1:0] cmode;
      logic       wp;
   } ttw_attr_t;

   function automatic ttw_attr_t attr_of(input logic [CFG_W-1:0] c);
      ttw_attr_t a;
      a.upa   = c[UPA_HI:UPA_LO];
      a.cmode = c[CM_HI:CM_LO];
      a.wp    = c[WP_BIT];
      return a;
   endfunction

endpackage

// File: rtl/ttw_regfile.sv
module ttw_regfile
   import ttw_pkg::*;
#(
   parameter int unsigned NREG  = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [CFG_W-1:0]            wdata,
   output logic [CFG_W-1:0]            rdata,
   output logic [NREG-1:0][CFG_W-1:0]  cfg_o
);

   logic [NREG-1:0][CFG_W-1:0] regs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (we) begin
         for (int i = 0; i < int'(NREG); i++) begin
            if (sel == SEL_W'(i)) regs_q[i] <= wdata & ~RSVD_MASK;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(NREG); i++) begin
         if (sel == SEL_W'(i)) rdata = regs_q[i];
      end
   end

   assign cfg_o = regs_q;

endmodule

// File: rtl/ttw_window.sv
module ttw_window
   import ttw_pkg::*;
#(
   parameter int unsigned TAG_W = 8
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic [TAG_W-1:0] tag,
   input  logic             super_i,
   output logic             hit_o
);

   logic [TAG_W-1:0] base_b;
   logic [TAG_W-1:0] care_b;
   logic             addr_ok;
   logic             priv_ok;
   logic             unused_cfg;

   assign base_b  = cfg[BASE_MSB -: TAG_W];
   assign care_b  = ~cfg[MASK_MSB -: TAG_W];
   assign addr_ok = ((tag ^ base_b) & care_b) == '0;
   assign priv_ok = cfg[PRIV_HI] | (cfg[PRIV_LO] == super_i);
   assign hit_o   = cfg[EN_BIT] & priv_ok & addr_ok;

   assign unused_cfg = ^cfg[PRIV_LO-1:0];

endmodule

// File: rtl/ttw_select.sv
module ttw_select
   import ttw_pkg::*;
#(
   parameter int unsigned W     = 2,
   parameter int unsigned IDX_W = 1
) (
   input  logic [W-1:0]             match_i,
   input  logic [W-1:0][CFG_W-1:0]  cfg_i,
   output logic                     any_o,
   output logic [IDX_W-1:0]         idx_o,
   output ttw_attr_t                attr_o
);

   logic [CFG_W-1:0] win_cfg;
   logic             unused_bits;

   assign any_o = |match_i;

   always_comb begin
      idx_o   = '0;
      win_cfg = cfg_i[0];
      for (int k = int'(W) - 1; k >= 0; k--) begin
         if (match_i[k]) begin
            idx_o   = IDX_W'(k);
            win_cfg = cfg_i[k];
         end
      end
   end

   assign attr_o = attr_of(win_cfg);

   assign unused_bits = ^{win_cfg[31:10], win_cfg[7], win_cfg[4:3], win_cfg[1:0]};

endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
   import ttw_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned TAG_W   = 8,
   parameter int unsigned WPAIR   = 2,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned NREG   = 2 * WPAIR,
   localparam int unsigned SEL_W  = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int unsigned IDX_W  = (WPAIR > 1) ? $clog2(WPAIR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_instr,
   input  logic              acc_super,
   input  logic              acc_write,
   input  logic              xlate_en,
   input  logic              xlate_dis,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [1:0]        rsp_upa,
   output logic [1:0]        rsp_cmode,
   output logic              rsp_wp
);

   if (TAG_W != 8) begin : g_bad_tag
      $error("ttw_matcher: TAG_W must be 8 to fit the configuration layout");
   end
   if (ADDR_W < TAG_W + 1) begin : g_bad_addr
      $error("ttw_matcher: ADDR_W must exceed TAG_W");
   end
   if (WPAIR < 1) begin : g_bad_pair
      $error("ttw_matcher: WPAIR must be at least 1");
   end

   logic [NREG-1:0][CFG_W-1:0]  cfg_all;
   logic [NREG-1:0]             match_all;
   logic [WPAIR-1:0]            pair_match;
   logic [WPAIR-1:0][CFG_W-1:0] pair_cfg;
   logic [TAG_W-1:0]            tag;
   logic                        any_c;
   logic [IDX_W-1:0]            idx_c;
   ttw_attr_t                   attr_c;
   logic                        hit_c;
   logic                        fault_c;
   logic                        take_c;
   logic                        unused_in;

   assign tag       = acc_addr[ADDR_W-1 -: TAG_W];
   assign unused_in = ^{xlate_en, xlate_dis, acc_addr[ADDR_W-TAG_W-1:0]};

   ttw_regfile #(
      .NREG  (NREG),
      .SEL_W (SEL_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg_o (cfg_all)
   );

   for (genvar g = 0; g < int'(NREG); g++) begin : g_win
      ttw_window #(
         .TAG_W (TAG_W)
      ) u_win (
         .cfg     (cfg_all[g]),
         .tag     (tag),
         .super_i (acc_super),
         .hit_o   (match_all[g])
      );
   end

   assign pair_match = acc_instr ? match_all[NREG-1:WPAIR] : match_all[WPAIR-1:0];
   assign pair_cfg   = acc_instr ? cfg_all[NREG-1:WPAIR]   : cfg_all[WPAIR-1:0];

   ttw_select #(
      .W     (WPAIR),
      .IDX_W (IDX_W)
   ) u_sel (
      .match_i (pair_match),
      .cfg_i   (pair_cfg),
      .any_o   (any_c),
      .idx_o   (idx_c),
      .attr_o  (attr_c)
   );

   assign take_c  = acc_valid & any_c;
   assign fault_c = take_c & acc_write & attr_c.wp;
   assign hit_c   = take_c & ~fault_c;

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_idx   <= '0;
            rsp_upa   <= '0;
            rsp_cmode <= '0;
            rsp_wp    <= 1'b0;
         end else begin
            rsp_valid <= acc_valid;
            rsp_hit   <= hit_c;
            rsp_fault <= fault_c;
            rsp_idx   <= take_c ? idx_c        : '0;
            rsp_upa   <= take_c ? attr_c.upa   : '0;
            rsp_cmode <= take_c ? attr_c.cmode : '0;
            rsp_wp    <= take_c & attr_c.wp;
         end
      end
   end else begin : g_ocomb
      assign rsp_valid = acc_valid;
      assign rsp_hit   = hit_c;
      assign rsp_fault = fault_c;
      assign rsp_idx   = take_c ? idx_c        : '0;
      assign rsp_upa   = take_c ? attr_c.upa   : '0;
      assign rsp_cmode = take_c ? attr_c.cmode : '0;
      assign rsp_wp    = take_c & attr_c.wp;
   end

endmodule

// File: rtl/ttw_checker.sv
module ttw_checker
   import ttw_pkg::*;
#(
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned IDX_W   = 1,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [SEL_W-1:0]  cfg_sel,
   input logic [CFG_W-1:0]  cfg_wdata,
   input logic [CFG_W-1:0]  cfg_rdata,
   input logic              acc_valid,
   input logic              acc_write,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_fault,
   input logic [IDX_W-1:0]  rsp_idx,
   input logic [1:0]        rsp_upa,
   input logic [1:0]        rsp_cmode,
   input logic              rsp_wp
);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & RSVD_MASK) == '0);

   // R9
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fault));

   // R9
   fault_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_wp);

   // R8
   idle_attr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit || rsp_fault) |-> (rsp_idx == '0 && rsp_upa == '0 && rsp_cmode == '0 && !rsp_wp));

   // R11
   no_result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_fault));

   if (OUT_REG) begin : g_seq
      // R11
      valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (rsp_valid == $past(acc_valid)));

      // R9
      fault_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && rsp_fault) |-> $past(acc_write));

      // R2
      wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(cfg_we) && cfg_sel == $past(cfg_sel))
            |-> (cfg_rdata == ($past(cfg_wdata) & ~RSVD_MASK)));
   end

endmodule

bind ttw_matcher ttw_checker #(
   .SEL_W   (SEL_W),
   .IDX_W   (IDX_W),
   .OUT_REG (OUT_REG)
) u_ttw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_fault (rsp_fault),
   .rsp_idx   (rsp_idx),
   .rsp_upa   (rsp_upa),
   .rsp_cmode (rsp_cmode),
   .rsp_wp    (rsp_wp)
);

// File: tb/ttw_matcher_bench.sv
module ttw_matcher_bench;

   localparam logic [31:0] RSVD = 32'h0000_1C9B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_instr = 1'b0;
   logic        acc_super = 1'b0;
   logic        acc_write = 1'b0;
   logic        xlate_en = 1'b0;
   logic        xlate_dis = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_wp;
   logic [0:0]  rsp_idx;
   logic [1:0]  rsp_upa, rsp_cmode;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   logic [31:0] model [4];
   logic        e_valid, e_hit, e_fault, e_wp;
   logic        e_idx;
   logic [1:0]  e_upa, e_cmode;

   always #5 clk = ~clk;

   ttw_matcher u_ttw_matcher (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_instr(acc_instr), .acc_super(acc_super),
      .acc_write(acc_write), .xlate_en(xlate_en), .xlate_dis(xlate_dis),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_idx(rsp_idx), .rsp_upa(rsp_upa), .rsp_cmode(rsp_cmode), .rsp_wp(rsp_wp)
   );

   function automatic logic [31:0] mk(input int base, input int mask, input bit en,
                                      input int priv, input int upa, input int cm, input bit wp);
      logic [31:0] v;
      v = 32'h0;
      v[31:24] = base[7:0];
      v[23:16] = mask[7:0];
      v[15]    = en;
      v[14:13] = priv[1:0];
      v[9:8]   = upa[1:0];
      v[6:5]   = cm[1:0];
      v[2]     = wp;
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s/%s at %0t: actual %h expected %h", cur_req, tag, $time, act, exp);
      end
   endtask

   // Reference model: evaluates on each edge, compares 3 ns after.
   always @(posedge clk) begin
      int  first;
      logic [31:0] w;
      logic [31:0] wc;
      first = -1;
      wc = 32'h0;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) model[i] = 32'h0;
         e_valid = 0; e_hit = 0; e_fault = 0; e_idx = 0;
         e_upa = 0; e_cmode = 0; e_wp = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            w = model[(acc_instr ? 2 : 0) + k];
            if (first < 0 && w[15] && (w[14] || (w[13] == acc_super))
                && (((acc_addr[31:24] ^ w[31:24]) & ~w[23:16]) == 8'h00)) begin
               first = k;
               wc = w;
            end
         end
         e_valid = acc_valid;
         e_fault = acc_valid && first >= 0 && acc_write && wc[2];
         e_hit   = acc_valid && first >= 0 && !e_fault;
         if (e_hit || e_fault) begin
            e_idx = first[0]; e_upa = wc[9:8]; e_cmode = wc[6:5]; e_wp = wc[2];
         end else begin
            e_idx = 0; e_upa = 0; e_cmode = 0; e_wp = 0;
         end
         if (cfg_we) model[cfg_sel] = cfg_wdata & ~RSVD;
      end
      #3;
      chk("R11 valid", 32'(rsp_valid), 32'(e_valid));
      chk("R3 hit",    32'(rsp_hit),   32'(e_hit));
      chk("R9 fault",  32'(rsp_fault), 32'(e_fault));
      chk("R7 idx",    32'(rsp_idx),   32'(e_idx));
      chk("R8 attr",   {27'h0, rsp_upa, rsp_cmode, rsp_wp}, {27'h0, e_upa, e_cmode, e_wp});
      chk("R2 rdata",  cfg_rdata, rst_n ? model[cfg_sel] : 32'h0);
   end

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel[1:0]; cfg_wdata = d; acc_valid = 0;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic rd(input int sel);
      @(negedge clk);
      cfg_we = 0; cfg_sel = sel[1:0]; acc_valid = 0;
   endtask

   task automatic acc(input logic [7:0] top, input bit ins, input bit sup, input bit w);
      @(negedge clk);
      cfg_we = 0; acc_valid = 1;
      acc_addr = {top, 24'h5A_3C_71};
      acc_instr = ins; acc_super = sup; acc_write = w;
      @(negedge clk);
      acc_valid = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset contents and no hit
      cur_req = "R1";
      for (int s = 0; s < 4; s++) rd(s);
      acc(8'h00, 0, 0, 0);
      acc(8'h00, 1, 1, 0);
      // R2: full word write, reserved bits read zero
      cur_req = "R2";
      wr(0, 32'hFFFF_FFFF); rd(0);
      wr(3, 32'h1234_5678); rd(3);
      wr(3, 32'h0); wr(0, 32'h0);
      // R3: base and mask
      cur_req = "R3";
      wr(0, mk(8'h40, 8'h00, 1, 2, 2, 1, 0) | RSVD);
      acc(8'h40, 0, 0, 0); acc(8'h41, 0, 0, 0); acc(8'hC0, 0, 1, 0);
      wr(1, mk(8'h80, 8'h0F, 1, 3, 1, 3, 0));
      acc(8'h8A, 0, 0, 0); acc(8'h8F, 0, 1, 0); acc(8'h90, 0, 0, 0);
      // R4: enable
      cur_req = "R4";
      wr(1, mk(8'h80, 8'h0F, 0, 3, 1, 3, 0));
      acc(8'h8A, 0, 0, 0);
      // R5: privilege qualifier
      cur_req = "R5";
      wr(0, mk(8'h40, 8'h00, 1, 0, 1, 2, 0));
      acc(8'h40, 0, 0, 0); acc(8'h40, 0, 1, 0);
      wr(0, mk(8'h40, 8'h00, 1, 1, 1, 2, 0));
      acc(8'h40, 0, 0, 0); acc(8'h40, 0, 1, 0);
      wr(0, mk(8'h40, 8'h00, 1, 3, 1, 2, 0));
      acc(8'h40, 0, 0, 0); acc(8'h40, 0, 1, 0);
      // R6: pair separation
      cur_req = "R6";
      wr(2, mk(8'h20, 8'h00, 1, 2, 3, 1, 0));
      acc(8'h20, 0, 0, 0); acc(8'h20, 1, 0, 0); acc(8'h40, 1, 0, 0);
      // R7: priority inside a pair
      cur_req = "R7";
      wr(1, mk(8'h00, 8'hFF, 1, 2, 2, 3, 0));
      acc(8'h40, 0, 0, 0); acc(8'h77, 0, 0, 0);
      wr(0, 32'h0);
      acc(8'h40, 0, 0, 0);
      wr(3, mk(8'h21, 8'h01, 1, 2, 1, 0, 0));
      acc(8'h20, 1, 1, 0); acc(8'h21, 1, 1, 0);
      // R8 and R9: attributes and write protect
      cur_req = "R9";
      wr(0, mk(8'h40, 8'h00, 1, 2, 3, 2, 1));
      acc(8'h40, 0, 0, 1); acc(8'h40, 0, 0, 1); acc(8'h40, 0, 0, 0);
      acc(8'h55, 0, 0, 1);
      cur_req = "R8";
      wr(0, mk(8'h40, 8'h00, 1, 2, 1, 1, 0));
      acc(8'h40, 0, 0, 1); acc(8'h13, 0, 0, 0);
      // R10: ignored control inputs
      cur_req = "R10";
      for (int m = 0; m < 4; m++) begin
         xlate_en = m[0]; xlate_dis = m[1];
         acc(8'h40, 0, 0, 0); acc(8'h20, 1, 1, 0); acc(8'h99, 0, 0, 0);
      end
      // R11: same-cycle write sees old config, no access means no hit
      cur_req = "R11";
      @(negedge clk);
      cfg_we = 1; cfg_sel = 0; cfg_wdata = 32'h0;
      acc_valid = 1; acc_addr = 32'h40_00_00_00; acc_instr = 0; acc_super = 0; acc_write = 0;
      @(negedge clk);
      cfg_we = 0; acc_valid = 1;
      @(negedge clk);
      acc_valid = 0; acc_addr = 32'h20_00_00_00; acc_instr = 1;
      @(negedge clk);
      // random mix, all requirements
      cur_req = "R3";
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         cfg_we    = ($urandom_range(0, 4) == 0);
         cfg_sel   = 2'($urandom_range(0, 3));
         cfg_wdata = $urandom;
         cfg_wdata[15] = ($urandom_range(0, 3) != 0);
         cfg_wdata[31:24] = 8'($urandom_range(0, 7)) << 5;
         cfg_wdata[23:16] = 8'($urandom_range(0, 3));
         acc_valid = ($urandom_range(0, 3) != 0);
         acc_addr  = $urandom;
         acc_addr[31:24] = (8'($urandom_range(0, 7)) << 5) | 8'($urandom_range(0, 3));
         acc_instr = 1'($urandom);
         acc_super = 1'($urandom);
         acc_write = 1'($urandom);
         xlate_en  = 1'($urandom);
         xlate_dis = 1'($urandom);
      end
      @(negedge clk);
      cfg_we = 0; acc_valid = 0;
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule